// File: doc/BRIEF.md
# Non-forwarding pipeline interlock unit

This unit decides, cycle by cycle, whether the instruction sitting in decode may move into execute in an in-order six-stage pipeline. The six stages are fetch, decode, execute, first memory, second memory and writeback. The pipeline has no bypass paths, so a source register can be read only once its producer has left writeback. The register file cannot read and write a register in the same cycle, so the read must come in a later cycle than the write.

Each cycle the front end presents the decode instruction's two source fields with their use flags, its destination field with a write flag, and a branch flag. The unit keeps a small record of every instruction in execute, first memory, second memory and writeback. When the decode instruction conflicts with that record, or a branch is still being resolved in execute, the unit raises `stall_o`. That signal holds fetch and decode, and an empty slot goes into execute for that cycle. When the instruction finally moves on, `issue_o` pulses and `issue_stalls_o` gives the number of cycles the instruction was held.

Top module: `ilk_interlock`

## Requirements
- R1: After a synchronous active-high reset, no in-flight record exists. The first instruction presented therefore issues with no stall, and `issue_stalls_o` reads 0.
- R2: Take a consumer whose used first source matches the destination of the instruction issued in the cycle just before. It is held for exactly 4 cycles, while the producer is in execute, first memory, second memory and writeback. It issues in the cycle after the producer leaves writeback.
- R3: A used second source creates the same dependency as in R2. A source whose use flag is 0 never causes a stall.
- R4: When k instructions with no conflict separate the producer from the consumer, the consumer is held for max(0, 4-k) cycles.
- R5: Register 0 never creates a dependency, either as a source or as a destination. An instruction whose write flag is 0 creates no dependency.
- R6: The instruction right after a branch is held for exactly 1 cycle, while the branch is in execute.
- R7: In a cycle with `stall_o` high, `issue_o` is low and an empty slot with no destination enters execute. A held instruction is therefore recorded only once, when it issues.
- R8: In the cycle `issue_o` is high, `issue_stalls_o` equals the number of cycles that instruction spent with `stall_o` high.
- R9: While `id_valid` is low, `stall_o` and `issue_o` are both low.
- R10: `issue_stalls_o` saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_rs1 | input | REG_W | First source register |
| id_rs1_used | input | 1 | First source is read |
| id_rs2 | input | REG_W | Second source register |
| id_rs2_used | input | 1 | Second source is read |
| id_rd | input | REG_W | Destination register |
| id_rd_we | input | 1 | Instruction writes its destination |
| id_branch | input | 1 | Instruction is a branch |
| stall_o | output | 1 | Hold fetch and decode and inject an empty slot |
| issue_o | output | 1 | Decode instruction moves into execute at this edge |
| issue_stalls_o | output | CNT_W | Cycles the issuing instruction was held |

## Verification
The bench builds the unit with REG_W at its default of 5 and CNT_W lowered to 2. With CNT_W at 2, a back-to-back dependency, which costs 4 cycles, overflows the counter, so the saturation rule is reached under normal traffic. The bench also measures each hold from `stall_o`, which lets it confirm the full 4-cycle wait independently of the saturated count. Producer-to-consumer distances of zero to four instructions, idle gaps while producers drain, and a branch whose own source is still in flight are all exercised.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    parameter int REG_W   = 5;
    parameter int N_SLOTS = 4;              // execute, mem1, mem2, writeback
    localparam int EX_IDX = 0;
    localparam int WB_IDX = N_SLOTS - 1;

    typedef struct packed {
        logic             wr;   // slot will write rd
        logic             br;   // slot holds an unresolved branch
        logic [REG_W-1:0] rd;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '0;

    function automatic logic src_hits(slot_t s, logic [REG_W-1:0] r, logic used);
        return used && (r != '0) && s.wr && (s.rd == r);
    endfunction
endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
    import ilk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  slot_t                 push_slot,
    output slot_t [N_SLOTS-1:0]   slots
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
        end else begin
            slots[EX_IDX] <= push ? push_slot : EMPTY_SLOT;
            for (int i = 1; i < N_SLOTS; i++) begin
                slots[i] <= slots[i-1];
            end
        end
    end

    // R5: no in-flight record ever names register 0 as a destination
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_chk
        assert_no_x0_R5: assert property (@(posedge clk) disable iff (rst)
            slots[g].wr |-> (slots[g].rd != '0));
    end
endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
(
    input  slot_t [N_SLOTS-1:0] slots,
    input  logic [REG_W-1:0]    rs1,
    input  logic                rs1_used,
    input  logic [REG_W-1:0]    rs2,
    input  logic                rs2_used,
    output logic                raw_hit,
    output logic                br_hit
);
    logic [N_SLOTS-1:0] hit;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        assign hit[g] = src_hits(slots[g], rs1, rs1_used) |
                        src_hits(slots[g], rs2, rs2_used);
    end

    assign raw_hit = |hit;
    assign br_hit  = slots[EX_IDX].br;
endmodule

// File: rtl/ilk_stall_counter.sv
module ilk_stall_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             issue,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || issue) begin
            count <= '0;
        end else if (hold && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    // R8: every instruction starts counting from zero
    assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (rst)
        issue |=> (count == '0));
endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                id_valid,
    input  logic [REG_W-1:0]    id_rs1,
    input  logic                id_rs1_used,
    input  logic [REG_W-1:0]    id_rs2,
    input  logic                id_rs2_used,
    input  logic [REG_W-1:0]    id_rd,
    input  logic                id_rd_we,
    input  logic                id_branch,
    output logic                stall_o,
    output logic                issue_o,
    output logic [CNT_W-1:0]    issue_stalls_o
);
    slot_t [N_SLOTS-1:0] slots;
    slot_t               new_slot;
    logic                raw_hit;
    logic                br_hit;

    always_comb begin
        new_slot    = EMPTY_SLOT;
        new_slot.wr = id_rd_we && (id_rd != '0);
        new_slot.br = id_branch;
        new_slot.rd = id_rd;
    end

    ilk_hazard u_hazard (
        .slots    (slots),
        .rs1      (id_rs1),
        .rs1_used (id_rs1_used),
        .rs2      (id_rs2),
        .rs2_used (id_rs2_used),
        .raw_hit  (raw_hit),
        .br_hit   (br_hit)
    );

    assign stall_o = id_valid && (raw_hit || br_hit);
    assign issue_o = id_valid && !stall_o;

    ilk_scoreboard u_sb (
        .clk       (clk),
        .rst       (rst),
        .push      (issue_o),
        .push_slot (new_slot),
        .slots     (slots)
    );

    ilk_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .hold  (stall_o),
        .issue (issue_o),
        .count (issue_stalls_o)
    );

    // R7: a stalled cycle sends an empty slot into execute
    assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (!slots[EX_IDX].wr && !slots[EX_IDX].br));

    // R6: a branch in execute holds the instruction behind it
    assert_branch_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (id_valid && slots[EX_IDX].br) |-> stall_o);

    // R9: an empty decode stage neither stalls nor issues
    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> (!stall_o && !issue_o));
endmodule

// File: tb/ilk_interlock_bench.sv
module ilk_interlock_bench;
    localparam int CNT_W = 2;
    localparam int SAT   = (1 << CNT_W) - 1;

    logic       clk = 0;
    logic       rst = 1;
    logic       id_valid = 0;
    logic [4:0] id_rs1 = 0, id_rs2 = 0, id_rd = 0;
    logic       id_rs1_used = 0, id_rs2_used = 0, id_rd_we = 0, id_branch = 0;
    logic       stall_o, issue_o;
    logic [CNT_W-1:0] issue_stalls_o;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    string tag_q[$];
    int held = 0;

    always #2.5 clk = ~clk;

    ilk_interlock #(.CNT_W(CNT_W)) u_ilk_interlock (
        .clk(clk), .rst(rst), .id_valid(id_valid),
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
        .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .id_rd(id_rd), .id_rd_we(id_rd_we), .id_branch(id_branch),
        .stall_o(stall_o), .issue_o(issue_o), .issue_stalls_o(issue_stalls_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: present one instruction and wait until it issues
    task automatic send(input logic [4:0] rs1, input logic u1, input logic [4:0] rs2,
                        input logic u2, input logic [4:0] rd, input logic we,
                        input logic br, input int exp, input string tag);
        bit got;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        id_valid = 1; id_rs1 = rs1; id_rs1_used = u1; id_rs2 = rs2;
        id_rs2_used = u2; id_rd = rd; id_rd_we = we; id_branch = br;
        do begin
            #1;
            got = issue_o;
            @(negedge clk);
        end while (!got);
    endtask

    // R9: decode empty, outputs quiet
    task automatic idle(input int n);
        id_valid = 0; id_branch = 0; id_rd_we = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            chk(!stall_o && !issue_o, "R9 idle", {30'd0, stall_o, issue_o}, 0);
            @(negedge clk);
        end
    endtask

    // monitor: pop expected hold and compare at each issue
    always begin
        @(negedge clk);
        #1;
        if (rst) begin
            held = 0;
        end else begin
            if (stall_o && issue_o) chk(0, "R7 stall with issue", 1, 0);
            if (id_valid && stall_o) held++;
            if (issue_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected issue", 1, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(held == e, {t, " held cycles"}, held, e);
                    chk(int'(issue_stalls_o) == ((e > SAT) ? SAT : e),
                        {t, " R8 reported count"}, int'(issue_stalls_o),
                        (e > SAT) ? SAT : e);
                end
                held = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!stall_o && !issue_o && issue_stalls_o == 0, "R1 reset outputs",
            {29'd0, stall_o, issue_o, 1'b0}, 0);
        rst = 0;
        @(negedge clk);
        // R1: empty record, nothing stalls
        send(5'd3, 1, 5'd3, 1, 5'd4, 1, 0, 0, "R1 first");
        idle(5);
        // R2 and R10: back-to-back on rs1, saturated report; R7 single record
        send(0, 0, 0, 0, 5'd1, 1, 0, 0, "R2 producer");
        send(5'd1, 1, 0, 0, 5'd2, 1, 0, 4, "R2 R10 consumer");
        send(5'd2, 1, 0, 0, 5'd0, 0, 0, 4, "R7 after held producer");
        idle(5);
        // R3: rs2 dependency; unused source ignored
        send(0, 0, 0, 0, 5'd5, 1, 0, 0, "R3 producer");
        send(0, 0, 5'd5, 1, 5'd0, 0, 0, 4, "R3 rs2 consumer");
        send(0, 0, 0, 0, 5'd6, 1, 0, 0, "R3 producer2");
        send(5'd6, 0, 5'd6, 0, 5'd0, 0, 0, 0, "R3 unused sources");
        idle(5);
        // R4: distances 1 to 4
        send(0, 0, 0, 0, 5'd7, 1, 0, 0, "R4 p1");
        send(0, 0, 0, 0, 5'd0, 0, 0, 0, "R4 gap");
        send(5'd7, 1, 0, 0, 5'd0, 0, 0, 3, "R4 distance1");
        idle(5);
        send(0, 0, 0, 0, 5'd8, 1, 0, 0, "R4 p2");
        for (int i = 0; i < 2; i++) send(0, 0, 0, 0, 5'd0, 0, 0, 0, "R4 gap");
        send(0, 0, 5'd8, 1, 5'd0, 0, 0, 2, "R4 distance2");
        idle(5);
        send(0, 0, 0, 0, 5'd9, 1, 0, 0, "R4 p3");
        for (int i = 0; i < 3; i++) send(0, 0, 0, 0, 5'd0, 0, 0, 0, "R4 gap");
        send(5'd9, 1, 0, 0, 5'd0, 0, 0, 1, "R4 distance3");
        idle(5);
        send(0, 0, 0, 0, 5'd9, 1, 0, 0, "R4 p4");
        for (int i = 0; i < 4; i++) send(0, 0, 0, 0, 5'd0, 0, 0, 0, "R4 gap");
        send(5'd9, 1, 0, 0, 5'd0, 0, 0, 0, "R4 distance4");
        idle(5);
        // R5: register 0 and non-writing producers
        send(0, 0, 0, 0, 5'd0, 1, 0, 0, "R5 x0 producer");
        send(5'd0, 1, 5'd0, 1, 5'd0, 0, 0, 0, "R5 x0 consumer");
        send(0, 0, 0, 0, 5'd10, 0, 0, 0, "R5 nonwriting producer");
        send(5'd10, 1, 0, 0, 5'd0, 0, 0, 0, "R5 nonwriting consumer");
        idle(5);
        // R6: branch holds its successor one cycle
        send(0, 0, 0, 0, 5'd0, 0, 1, 0, "R6 branch");
        send(0, 0, 0, 0, 5'd13, 1, 0, 1, "R6 after branch");
        send(0, 0, 0, 0, 5'd0, 0, 0, 0, "R6 second after branch");
        idle(5);
        send(0, 0, 0, 0, 5'd11, 1, 0, 0, "R6 producer");
        send(5'd11, 1, 0, 0, 5'd0, 0, 1, 4, "R6 dependent branch");
        send(0, 0, 0, 0, 5'd0, 0, 0, 1, "R6 after dependent branch");
        idle(5);
        // R9 with producer draining, then remaining wait
        send(0, 0, 0, 0, 5'd12, 1, 0, 0, "R9 producer");
        idle(2);
        send(5'd12, 1, 0, 0, 5'd0, 0, 0, 2, "R9 R4 consumer after idle");
        idle(3);
        chk(exp_q.size() == 0, "R8 all issued", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule